// File: doc/BRIEF.md
# Device Reset Sequencer with Retry

This block brings an attached PHY/MAC device out of reset by driving its active-low reset pin through a fixed power-up sequence. A start request begins the sequence. The pin goes low for a first hold interval. The block then waits for the device's external clocks to report stable, and holds the pin low for a second interval. After the pin is released, two settle intervals follow: one for the device's internal clock synthesiser and one for its serial link. Every interval is given in microseconds and turned into clock cycles from a clock-frequency parameter.

When the settle intervals end, the block samples the device's status flags. The attempt passes only if the synthesiser timer-expired flag is set, the serial PLL timer-expired flag is set and every lock-loss flag is clear. If the attempt fails and the attempt budget is not used up, the whole sequence runs again. When the block finishes, it gives a one-cycle done pulse, a pass/fail result and the number of attempts used. The result stays valid until the next start.

Top module: `dev_reset_seq`

## Requirements
- R1: After rst_ni is released and before any start, dev_rst_no is 0, and busy_o, done_o, pass_o and attempts_o are all 0.
- R2: A start_i sampled high while idle makes dev_rst_no 0, busy_o 1 and attempts_o 1 on the following cycle.
- R3: With clk_stable_i already high, each attempt holds dev_rst_no low for PRE_CYC + 1 + POST_CYC cycles. Each cycle count is CLK_HZ * interval_us / 1e6, with a minimum of 1.
- R4: After the first hold interval, dev_rst_no stays low for as long as clk_stable_i is low. The second hold interval starts only once clk_stable_i is high.
- R5: After dev_rst_no is released, the status flags are sampled SYN_CYC + LINK_CYC cycles later. That same edge ends the attempt.
- R6: An attempt passes only if synth_expired_i = 1, serdes_expired_i = 1 and every bit of lock_lost_i = 0.
- R7: A failed attempt restarts the sequence with dev_rst_no low, up to MAX_ATTEMPTS attempts in total. attempts_o gives the number of the current or last attempt.
- R8: If the last attempt fails, the block raises done_o with pass_o = 0 and attempts_o = MAX_ATTEMPTS, and leaves dev_rst_no low.
- R9: A start_i that arrives while busy_o is 1 is ignored. The attempt count and the interval timing are unchanged.
- R10: done_o lasts exactly one cycle, in the cycle where busy_o falls. pass_o and attempts_o hold until the next start, and dev_rst_no stays high after a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock of frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Request to run the reset sequence |
| clk_stable_i | input | 1 | External clocks of the device are stable |
| synth_expired_i | input | 1 | Device clock-synthesiser timer expired |
| serdes_expired_i | input | 1 | Device serial-link PLL timer expired |
| lock_lost_i | input | LOCK_W | Lock-loss flags, all must be clear to pass |
| dev_rst_no | output | 1 | Active-low reset pin to the device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| pass_o | output | 1 | Result of the last sequence, 1 is pass |
| attempts_o | output | ATT_W | Current or last attempt number |

## Verification
Some properties are checked by assertions on every cycle. done_o never coincides with busy_o and never lasts two cycles. The pin rises only inside a sequence, and the attempt count never exceeds its limit and changes only while the pin is low. The timer also never wraps below zero. The exact hold and settle lengths, the pass rule for each status flag, the retry that recovers on the second attempt, the stall on an unstable clock, and the ignored start during a sequence can only be shown by the bench's scenarios. A scoreboard compares the measured pin-low and pin-high runs, the result and the attempt count against values computed from the requirements.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD_PRE,
    ST_WAIT_CLK,
    ST_HOLD_POST,
    ST_SETTLE_SYN,
    ST_SETTLE_LINK
  } rsq_state_e;

  function automatic longint unsigned us_to_cyc(longint unsigned hz, longint unsigned us);
    longint unsigned c;
    c = (hz * us) / 64'd1_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction
endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  // loading N keeps expired_o low for N-1 cycles, so the owning state lasts N cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R3
  timer_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rsq_status_eval.sv
module rsq_status_eval #(
  parameter int LOCK_W = 2
) (
  input  logic              synth_expired_i,
  input  logic              serdes_expired_i,
  input  logic [LOCK_W-1:0] lock_lost_i,
  output logic              ok_o
);
  // R6
  assign ok_o = synth_expired_i && serdes_expired_i && (lock_lost_i == '0);
endmodule

// File: rtl/dev_reset_seq.sv
module dev_reset_seq
  import rsq_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 156_250_000,
  parameter int              PRE_US       = 1000,
  parameter int              POST_US      = 2000,
  parameter int              SYN_US       = 15000,
  parameter int              LINK_US      = 1000,
  parameter int              MAX_ATTEMPTS = 3,
  parameter int              LOCK_W       = 2,
  parameter int              ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              clk_stable_i,
  input  logic              synth_expired_i,
  input  logic              serdes_expired_i,
  input  logic [LOCK_W-1:0] lock_lost_i,
  output logic              dev_rst_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [ATT_W-1:0]  attempts_o
);
  localparam longint unsigned PRE_CYC  = us_to_cyc(CLK_HZ, PRE_US);
  localparam longint unsigned POST_CYC = us_to_cyc(CLK_HZ, POST_US);
  localparam longint unsigned SYN_CYC  = us_to_cyc(CLK_HZ, SYN_US);
  localparam longint unsigned LINK_CYC = us_to_cyc(CLK_HZ, LINK_US);
  localparam longint unsigned MAX_CYC  =
    (PRE_CYC > POST_CYC ? PRE_CYC : POST_CYC) > (SYN_CYC > LINK_CYC ? SYN_CYC : LINK_CYC) ?
    (PRE_CYC > POST_CYC ? PRE_CYC : POST_CYC) : (SYN_CYC > LINK_CYC ? SYN_CYC : LINK_CYC);
  localparam int TW = $clog2(MAX_CYC + 1);
  localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_ATTEMPTS);

  rsq_state_e state_q, state_d;
  logic             rst_q, rst_d, busy_q, busy_d, done_q, done_d, pass_q, pass_d;
  logic [ATT_W-1:0] att_q, att_d;
  logic             tmr_load, tmr_exp, stat_ok;
  logic [TW-1:0]    tmr_val;

  rsq_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  rsq_status_eval #(.LOCK_W(LOCK_W)) u_eval (
    .synth_expired_i  (synth_expired_i),
    .serdes_expired_i (serdes_expired_i),
    .lock_lost_i      (lock_lost_i),
    .ok_o             (stat_ok)
  );

  always_comb begin
    state_d  = state_q;
    rst_d    = rst_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    pass_d   = pass_q;
    att_d    = att_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(PRE_CYC);
    unique case (state_q)
      ST_IDLE: if (start_i) begin            // R2, R9: start only sampled here
        state_d  = ST_HOLD_PRE;
        rst_d    = 1'b0;
        busy_d   = 1'b1;
        pass_d   = 1'b0;
        att_d    = ATT_W'(1);
        tmr_load = 1'b1;
      end
      ST_HOLD_PRE: if (tmr_exp) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clk_stable_i) begin   // R4
        state_d  = ST_HOLD_POST;
        tmr_load = 1'b1;
        tmr_val  = TW'(POST_CYC);
      end
      ST_HOLD_POST: if (tmr_exp) begin
        state_d  = ST_SETTLE_SYN;
        rst_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(SYN_CYC);
      end
      ST_SETTLE_SYN: if (tmr_exp) begin
        state_d  = ST_SETTLE_LINK;
        tmr_load = 1'b1;
        tmr_val  = TW'(LINK_CYC);
      end
      ST_SETTLE_LINK: if (tmr_exp) begin     // R5
        if (stat_ok) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
          pass_d  = 1'b1;
        end else if (att_q == ATT_LAST) begin // R8
          state_d = ST_IDLE;
          rst_d   = 1'b0;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end else begin                        // R7
          state_d  = ST_HOLD_PRE;
          rst_d    = 1'b0;
          att_d    = att_q + 1'b1;
          tmr_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rst_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      att_q   <= '0;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      att_q   <= att_d;
    end
  end

  assign dev_rst_no = rst_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign attempts_o = att_q;

  // R10
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  release_in_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_no) |-> busy_o);
  // R7
  attempts_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attempts_o <= ATT_LAST);
  // R7
  attempt_step_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attempts_o != $past(attempts_o)) |-> !dev_rst_no);
  // R10
  pass_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> done_o);
endmodule

// File: tb/dev_reset_seq_test.sv
module dev_reset_seq_test;
  localparam int HA = 10, HB = 20, SY = 150, LK = 10;
  localparam int LOW_RUN = HA + 1 + HB;
  localparam int HIGH_RUN = SY + LK;

  logic       clk = 0, rst_n = 0, start = 0, clk_stable = 1;
  logic       syn_exp = 1, ser_exp = 1;
  logic [1:0] lock_lost = 0;
  logic       dev_rst_n, busy, done, pass;
  logic [1:0] att;

  int n_chk = 0, n_fail = 0;
  int low_run = 0, high_run = 0;
  logic prev_lvl = 1;

  typedef struct { logic ps; int at; int lo; int hi; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  dev_reset_seq #(.CLK_HZ(10_000), .LOCK_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clk_stable_i(clk_stable),
    .synth_expired_i(syn_exp), .serdes_expired_i(ser_exp), .lock_lost_i(lock_lost),
    .dev_rst_no(dev_rst_n), .busy_o(busy), .done_o(done), .pass_o(pass), .attempts_o(att)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: measures pin runs and scores each completion
  always @(negedge clk) begin
    if (done) begin
      exp_t e;
      if (sb_q.size() == 0) check(0, "R10 unexpected done", 1, 0);
      else begin
        e = sb_q.pop_front();
        check(pass == e.ps, {e.tag, " pass"}, pass, e.ps);
        check(int'(att) == e.at, {e.tag, " attempts"}, att, e.at);
        if (e.lo >= 0) check(low_run == e.lo, {e.tag, " R3 low run"}, low_run, e.lo);
        check(high_run == e.hi, {e.tag, " R5 high run"}, high_run, e.hi);
      end
    end
    if (!busy) begin
      low_run = 0; high_run = 0; prev_lvl = 1;
    end else if (!dev_rst_n) begin
      low_run = prev_lvl ? 1 : low_run + 1; prev_lvl = 0;
    end else begin
      high_run = !prev_lvl ? 1 : high_run + 1; prev_lvl = 1;
    end
  end

  // driver
  task automatic run(logic ps, int at, int lo, string tag);
    exp_t e;
    e.ps = ps; e.at = at; e.lo = lo; e.hi = HIGH_RUN; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy && !dev_rst_n && att == 1, "R2 start response", {busy, dev_rst_n, att}, 4'b1001);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R10 done one cycle", done, 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        check(0, "watchdog", wd, 0);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!dev_rst_n, "R1 pin", dev_rst_n, 0);
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!pass, "R1 pass", pass, 0);
    check(att == 0, "R1 attempts", att, 0);

    // R3 R5 R6 nominal pass
    run(1, 1, LOW_RUN, "R6 nominal");
    repeat (20) @(negedge clk);
    // R10 result holds
    check(pass && att == 1, "R10 result hold", {pass, att}, 3'b101);
    check(dev_rst_n, "R10 pin high after pass", dev_rst_n, 1);

    // R6 R8 each flag alone causes full failure
    syn_exp = 0;
    run(0, 3, LOW_RUN, "R8 synth flag");
    check(!dev_rst_n, "R8 pin low after fail", dev_rst_n, 0);
    syn_exp = 1; ser_exp = 0;
    run(0, 3, LOW_RUN, "R6 serdes flag");
    ser_exp = 1; lock_lost = 2'b10;
    run(0, 3, LOW_RUN, "R6 lock flag");
    repeat (15) @(negedge clk);
    check(!pass && att == 3 && !dev_rst_n, "R10 fail hold", {pass, att, dev_rst_n}, 4'b0110);
    lock_lost = 0;

    // R7 recovers on second attempt
    syn_exp = 0;
    fork
      run(1, 2, LOW_RUN, "R7 retry");
      begin
        while (att != 2) @(negedge clk);
        syn_exp = 1;
      end
    join

    // R4 stall while clock unstable
    clk_stable = 0;
    fork
      run(1, 1, -1, "R4 clk wait");
      begin
        repeat (HA + 60) @(negedge clk);
        check(!dev_rst_n && busy, "R4 held in reset", {dev_rst_n, busy}, 2'b01);
        clk_stable = 1;
      end
    join

    // R9 start during busy ignored
    fork
      run(1, 1, LOW_RUN, "R9 ignored start");
      begin
        repeat (40) @(negedge clk);
        start = 1;
        @(negedge clk); start = 0;
        check(att == 1 && busy, "R9 attempts unchanged", att, 1);
      end
    join

    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule